// File: doc/BRIEF.md
# PLL Bring-Up and Shutdown Sequencer

This block is a hardware sequencer that owns one PLL control word and walks it through a fixed power-up procedure when asked to, so that software does not have to time the steps. An enable request first moves the system clock selector onto the raw input clock. The sequencer then writes the four divider factors and turns the PLL power on. It gives the PLL a low-high-low reset pulse and watches the lock inputs, pulsing a slip-clear strobe on every cycle that lock is incomplete. When lock is complete it takes the PLL out of bypass and turns the output on in a single write, and finally returns the system clock selector to the PLL.

A disable request runs the reverse. Bypass is set on its own first, and only on the following write are power and output enable removed, so that clocks derived from the PLL keep running. If the PLL already reads as running when an enable arrives, the whole sequence is skipped. If lock does not appear within a bounded number of cycles, the sequencer flags an error and goes back to idle.

A combinational rate model reports the output frequency implied by the current control word for a given input rate. Requests are plain level-sampled pulses. A request is taken only while the sequencer is idle; at all other times it is dropped, with no queueing and no back-pressure.

Top module: `pll_seq_top`

## Requirements
- R1: After reset the control word is all zeros, the system clock select is 0 (raw input), busy, done and the error flag are 0, and the reported rate is 0.
- R2: When the reset bit (bit 20) first rises in an enable sequence, bits [19:0] already hold {bandwidth[19:14], output divider[13:10], feedback divider[9:4], reference divider[3:0]} and the power bit (bit 21) is 1.
- R3: The reset bit is low before the pulse, then high for exactly RST_HOLD cycles, then low again.
- R4: While the sequencer waits for lock, slip_clr is 1 in every cycle in which not all LOCK_W lock bits are 1. A partial lock pattern counts as not locked. slip_clr is never 1 outside the wait.
- R5: Once lock is complete, bypass (bit 23) is cleared and enable (bit 25) is set in the same write. The finished word has reset 0 and power 1.
- R6: If the word shows reset 0 with power and enable both 1 when an enable is requested, done pulses on the next cycle and neither the word nor the clock select changes.
- R7: With DRIVES_SYS set, sys_sel is 0 from before the factors are written until after the output is enabled, and is 1 when done pulses.
- R8: A disable first sets bypass while power and enable keep their values, and then clears power and enable on the next cycle. done pulses together with that second write.
- R9: out_rate is ref_rate when bypass is 1. It is 0 when bypass is 0 and power is 0. Otherwise it is ref_rate*(F+1)/((R+1)*(OD+1)), truncated.
- R10: If lock is not complete for LOCK_TMO consecutive wait cycles, err_timeout is set, busy falls in the same cycle, and enable stays 0.
- R11: busy is 1 from the cycle after a request is accepted until the cycle after done. A request arriving while busy is ignored.
- R12: With HAS_SRC_SEL set, bits [27:26] take src_sel when the factors are written. Otherwise they stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | Request the enable sequence (taken when idle) |
| dis_req | input | 1 | Request the disable sequence (taken when idle, enable wins) |
| ref_div | input | 4 | Reference divider value R |
| fb_div | input | 6 | Feedback divider value F |
| out_div | input | 4 | Output divider value OD |
| bw_adj | input | 6 | Bandwidth adjust value |
| src_sel | input | 2 | PLL input source choice, used when HAS_SRC_SEL is set |
| lock_in | input | LOCK_W | Lock status bits from the PLL |
| ref_rate | input | RATE_W | Input clock rate for the rate model |
| ctrl_word | output | 32 | PLL control word |
| slip_clr | output | 1 | Slip-clear strobe while lock is incomplete |
| sys_sel | output | 1 | System clock select: 0 raw input, 1 PLL |
| out_rate | output | RATE_W | Output rate implied by ctrl_word |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| err_timeout | output | 1 | Lock wait timed out; cleared by the next accepted request |

## Verification
The bench builds the block with LOCK_W=2, so the partial pattern 01 can be driven to show that only all-ones counts as lock. It uses LOCK_TMO=40, which makes the timeout path reachable within a few dozen cycles of waiting. RST_HOLD=3 makes the measured reset width differ from the default. Both DRIVES_SYS and HAS_SRC_SEL are set, so the clock parking and the source field are visible at the ports.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int CW      = 32;
  localparam int REF_W   = 4;
  localparam int FB_W    = 6;
  localparam int OD_W    = 4;
  localparam int BW_W    = 6;
  localparam int FACT_W  = REF_W + FB_W + OD_W + BW_W;
  localparam int BIT_RST = 20;
  localparam int BIT_PWR = 21;
  localparam int BIT_BYP = 23;
  localparam int BIT_EN  = 25;
  localparam int SRC_LSB = 26;
  localparam int SRC_W   = 2;

  // packed order gives bw at [19:14], od at [13:10], fb at [9:4], rd at [3:0]
  typedef struct packed {
    logic [BW_W-1:0]  bw;
    logic [OD_W-1:0]  od;
    logic [FB_W-1:0]  fb;
    logic [REF_W-1:0] rd;
  } factors_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PARK, S_PROG, S_RLO, S_RHI, S_RREL,
    S_WAIT, S_RUN, S_RESEL, S_BYP, S_OFF, S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_RST_CLR, OP_RST_SET, OP_RUN, OP_BYP, OP_OFF
  } reg_op_t;
endpackage

// File: rtl/pll_seq_ctrlreg.sv
module pll_seq_ctrlreg
  import pll_seq_pkg::*;
#(
  parameter bit DRIVES_SYS  = 1'b1,
  parameter bit HAS_SRC_SEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_op_t          op,
  input  factors_t         factors,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             park,
  input  logic             resel,
  output logic [CW-1:0]    word,
  output logic             sys_sel,
  output logic             already_on
);
  logic [SRC_W-1:0] src_bits;

  generate
    if (HAS_SRC_SEL) begin : g_src
      assign src_bits = src_sel;
    end else begin : g_nosrc
      assign src_bits = '0;
    end
  endgenerate

  // one write per cycle; each op touches only its own bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else begin
      case (op)
        OP_PROG: begin
          word[FACT_W-1:0]         <= factors;
          word[BIT_PWR]            <= 1'b1;
          word[SRC_LSB +: SRC_W]   <= src_bits;
        end
        OP_RST_CLR: word[BIT_RST] <= 1'b0;
        OP_RST_SET: word[BIT_RST] <= 1'b1;
        OP_RUN: begin
          word[BIT_BYP] <= 1'b0;
          word[BIT_EN]  <= 1'b1;
        end
        OP_BYP: word[BIT_BYP] <= 1'b1;
        OP_OFF: begin
          word[BIT_PWR] <= 1'b0;
          word[BIT_EN]  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign already_on = !word[BIT_RST] && word[BIT_PWR] && word[BIT_EN];

  generate
    if (DRIVES_SYS) begin : g_sys
      logic sel_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= 1'b0;
        else if (park)  sel_q <= 1'b0;
        else if (resel) sel_q <= 1'b1;
      end
      assign sys_sel = sel_q;
    end else begin : g_nosys
      assign sys_sel = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pll_seq_lockmon.sv
module pll_seq_lockmon #(
  parameter int LOCK_W   = 2,
  parameter int LOCK_TMO = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              waiting,
  input  logic [LOCK_W-1:0] lock_in,
  output logic              lock_ok,
  output logic              slip_clr,
  output logic              tmo
);
  localparam int CNT_W = $clog2(LOCK_TMO + 1);
  logic [CNT_W-1:0] cnt;

  assign lock_ok  = &lock_in;
  assign slip_clr = waiting && !lock_ok;
  assign tmo      = slip_clr && (cnt == CNT_W'(LOCK_TMO - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !waiting) cnt <= '0;
    else if (!lock_ok)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int RST_HOLD = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_req,
  input  logic    dis_req,
  input  logic    already_on,
  input  logic    lock_ok,
  input  logic    tmo,
  output reg_op_t op,
  output logic    park,
  output logic    resel,
  output logic    waiting,
  output logic    busy,
  output logic    done,
  output logic    err
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  seq_state_t st, nxt;
  logic [HOLD_W-1:0] hcnt;
  logic accept;

  assign accept = (st == S_IDLE) && (en_req || dis_req);

  always_comb begin
    nxt   = st;
    op    = OP_NONE;
    park  = 1'b0;
    resel = 1'b0;
    case (st)
      S_IDLE: begin
        if (en_req)       nxt = already_on ? S_DONE : S_PARK;
        else if (dis_req) nxt = S_BYP;
      end
      S_PARK:  begin park = 1'b1;      nxt = S_PROG;  end
      S_PROG:  begin op = OP_PROG;     nxt = S_RLO;   end
      S_RLO:   begin op = OP_RST_CLR;  nxt = S_RHI;   end
      S_RHI: begin
        op = OP_RST_SET;
        if (hcnt == HOLD_W'(RST_HOLD - 1)) nxt = S_RREL;
      end
      S_RREL:  begin op = OP_RST_CLR;  nxt = S_WAIT;  end
      S_WAIT: begin
        if (lock_ok)  nxt = S_RUN;
        else if (tmo) nxt = S_IDLE;
      end
      S_RUN:   begin op = OP_RUN;      nxt = S_RESEL; end
      S_RESEL: begin resel = 1'b1;     nxt = S_DONE;  end
      S_BYP:   begin op = OP_BYP;      nxt = S_OFF;   end
      S_OFF:   begin op = OP_OFF;      nxt = S_DONE;  end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hcnt <= '0;
      err  <= 1'b0;
    end else begin
      st   <= nxt;
      hcnt <= (st == S_RHI) ? hcnt + 1'b1 : '0;
      if (accept)                        err <= 1'b0;
      else if (st == S_WAIT && tmo)      err <= 1'b1;
    end
  end

  assign waiting = (st == S_WAIT);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);
endmodule

// File: rtl/pll_seq_rate.sv
module pll_seq_rate
  import pll_seq_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic [RATE_W-1:0] ref_rate,
  input  factors_t          factors,
  input  logic              pwr,
  input  logic              byp,
  output logic [RATE_W-1:0] out_rate
);
  localparam int MW = FB_W + 1;
  localparam int PW = RATE_W + MW;
  localparam int DW = REF_W + OD_W + 2;

  logic [MW-1:0]     fbp1;
  logic [REF_W:0]    rdp1;
  logic [OD_W:0]     odp1;
  logic [DW-1:0]     denom;
  logic [PW-1:0]     prod, quot;

  assign fbp1  = MW'(factors.fb) + MW'(1);
  assign rdp1  = (REF_W+1)'(factors.rd) + (REF_W+1)'(1);
  assign odp1  = (OD_W+1)'(factors.od) + (OD_W+1)'(1);
  assign denom = DW'(rdp1) * DW'(odp1);
  assign prod  = PW'(ref_rate) * PW'(fbp1);
  assign quot  = prod / PW'(denom);

  always_comb begin
    if (byp)       out_rate = ref_rate;
    else if (!pwr) out_rate = '0;
    else           out_rate = quot[RATE_W-1:0];
  end
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
  import pll_seq_pkg::*;
#(
  parameter int LOCK_W      = 2,
  parameter int LOCK_TMO    = 4096,
  parameter int RST_HOLD    = 2,
  parameter int RATE_W      = 32,
  parameter bit DRIVES_SYS  = 1'b1,
  parameter bit HAS_SRC_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic [3:0]        ref_div,
  input  logic [5:0]        fb_div,
  input  logic [3:0]        out_div,
  input  logic [5:0]        bw_adj,
  input  logic [1:0]        src_sel,
  input  logic [LOCK_W-1:0] lock_in,
  input  logic [RATE_W-1:0] ref_rate,
  output logic [31:0]       ctrl_word,
  output logic              slip_clr,
  output logic              sys_sel,
  output logic [RATE_W-1:0] out_rate,
  output logic              busy,
  output logic              done,
  output logic              err_timeout
);
  reg_op_t  op;
  factors_t fin, fcur;
  logic park, resel, waiting, already_on, lock_ok, tmo;

  assign fin  = '{bw: bw_adj, od: out_div, fb: fb_div, rd: ref_div};
  assign fcur = factors_t'(ctrl_word[FACT_W-1:0]);

  pll_seq_fsm #(.RST_HOLD(RST_HOLD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .already_on(already_on), .lock_ok(lock_ok), .tmo(tmo), .op(op),
    .park(park), .resel(resel), .waiting(waiting), .busy(busy),
    .done(done), .err(err_timeout)
  );

  pll_seq_ctrlreg #(.DRIVES_SYS(DRIVES_SYS), .HAS_SRC_SEL(HAS_SRC_SEL)) u_reg (
    .clk(clk), .rst_n(rst_n), .op(op), .factors(fin), .src_sel(src_sel),
    .park(park), .resel(resel), .word(ctrl_word), .sys_sel(sys_sel),
    .already_on(already_on)
  );

  pll_seq_lockmon #(.LOCK_W(LOCK_W), .LOCK_TMO(LOCK_TMO)) u_lock (
    .clk(clk), .rst_n(rst_n), .waiting(waiting), .lock_in(lock_in),
    .lock_ok(lock_ok), .slip_clr(slip_clr), .tmo(tmo)
  );

  pll_seq_rate #(.RATE_W(RATE_W)) u_rate (
    .ref_rate(ref_rate), .factors(fcur), .pwr(ctrl_word[BIT_PWR]),
    .byp(ctrl_word[BIT_BYP]), .out_rate(out_rate)
  );
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int LOCK_W     = 2,
  parameter bit DRIVES_SYS = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LOCK_W-1:0] lock_in,
  input logic [31:0]       ctrl_word,
  input logic              slip_clr,
  input logic              sys_sel,
  input logic              busy,
  input logic              done,
  input logic              err_timeout
);
  logic lk;
  assign lk = &lock_in;

  assert_power_before_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[20]) |-> ctrl_word[21]);

  assert_slip_only_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slip_clr |-> !lk);

  assert_enable_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[25]) |-> ($past(lk, 2) && !ctrl_word[23]));

  assert_parked_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (DRIVES_SYS && ctrl_word[20]) |-> !sys_sel);

  assert_bypass_before_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_word[21]) |-> ($past(ctrl_word[23]) && ctrl_word[23]));

  assert_timeout_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (!busy && !ctrl_word[25]));

  assert_done_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind pll_seq_top pll_seq_chk #(.LOCK_W(LOCK_W), .DRIVES_SYS(DRIVES_SYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .ctrl_word(ctrl_word),
  .slip_clr(slip_clr), .sys_sel(sys_sel), .busy(busy), .done(done),
  .err_timeout(err_timeout)
);

// File: tb/pll_seq_top_bench.sv
module pll_seq_top_bench;
  localparam int LOCK_W = 2, LOCK_TMO = 40, RST_HOLD = 3, RATE_W = 32;

  logic clk = 1'b0, rst_n = 1'b0, en_req = 1'b0, dis_req = 1'b0;
  logic [3:0] ref_div = '0, out_div = '0;
  logic [5:0] fb_div = '0, bw_adj = '0;
  logic [1:0] src_sel = '0;
  logic [LOCK_W-1:0] lock_in = '0;
  logic [RATE_W-1:0] ref_rate = 32'd1000;
  logic [31:0] ctrl_word;
  logic slip_clr, sys_sel, busy, done, err_timeout;
  logic [RATE_W-1:0] out_rate;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pll_seq_top #(.LOCK_W(LOCK_W), .LOCK_TMO(LOCK_TMO), .RST_HOLD(RST_HOLD),
                .RATE_W(RATE_W), .DRIVES_SYS(1'b1), .HAS_SRC_SEL(1'b1)) u_pll_seq_top (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .ref_div(ref_div), .fb_div(fb_div), .out_div(out_div), .bw_adj(bw_adj),
    .src_sel(src_sel), .lock_in(lock_in), .ref_rate(ref_rate),
    .ctrl_word(ctrl_word), .slip_clr(slip_clr), .sys_sel(sys_sel),
    .out_rate(out_rate), .busy(busy), .done(done), .err_timeout(err_timeout)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fields(input logic [3:0] rd, input logic [5:0] fb,
                                         input logic [3:0] od, input logic [5:0] bw);
    return {12'd0, bw, od, fb, rd};
  endfunction

  function automatic longint rate_exp(input longint r, input logic [3:0] rd,
                                      input logic [5:0] fb, input logic [3:0] od);
    return (r * (longint'(fb) + 1)) / ((longint'(rd) + 1) * (longint'(od) + 1));
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // enable sequence with lock after dly wait cycles (or never)
  task automatic do_enable(input logic [3:0] rd, input logic [5:0] fb, input logic [3:0] od,
                           input logic [5:0] bw, input logic [1:0] src, input int dly,
                           input bit lk, input bit inj);
    bit prev_rst = 0, fell = 0, got_done = 0, got_err = 0;
    int hi = 0, n = 0, slips = 0;
    logic [31:0] expw;
    ref_div = rd; fb_div = fb; out_div = od; bw_adj = bw; src_sel = src;
    lock_in = '0;
    en_req = 1'b1;
    @(negedge clk);
    en_req = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (ctrl_word[20] && !prev_rst) begin
        check(ctrl_word[19:0] == fields(rd, fb, od, bw)[19:0] && ctrl_word[21], "R2 factors+power at reset rise",
              ctrl_word, fields(rd, fb, od, bw) | 32'h0030_0000);
        check(sys_sel == 1'b0, "R7 parked during reset", sys_sel, 0);
        hi = 0;
      end
      if (ctrl_word[20]) hi++;
      if (!ctrl_word[20] && prev_rst) begin
        check(hi == RST_HOLD, "R3 reset high width", hi, RST_HOLD);
        fell = 1; n = 0;
      end
      prev_rst = ctrl_word[20];
      if (done) begin got_done = 1; break; end
      if (err_timeout && !busy) begin got_err = 1; break; end
      if (fell) begin
        lock_in = (lk && n >= dly) ? 2'b11 : 2'b01;
        dis_req = inj && (n == 1);
        if (inj && n == 1) check(busy == 1'b1, "R11 busy while request arrives", busy, 1);
        n++;
      end
      #1;
      if (slip_clr) slips++;
      @(negedge clk);
    end
    dis_req = 1'b0;
    if (lk) begin
      expw = fields(rd, fb, od, bw) | (32'(src) << 26) | 32'h0220_0000;
      check(got_done, "R11 done pulse", got_done, 1);
      check(ctrl_word == expw, "R5 R12 final word", ctrl_word, expw);
      check(sys_sel == 1'b1, "R7 reselected", sys_sel, 1);
      check(slips == dly, "R4 slip count", slips, dly);
      check(out_rate == 32'(rate_exp(ref_rate, rd, fb, od)), "R9 locked rate",
            out_rate, rate_exp(ref_rate, rd, fb, od));
      @(negedge clk);
      check(busy == 1'b0, "R11 idle after done", busy, 0);
    end else begin
      check(got_err && !busy, "R10 timeout flag", err_timeout, 1);
      check(ctrl_word[25] == 1'b0, "R10 enable stays off", ctrl_word[25], 0);
      check(sys_sel == 1'b0, "R7 stays parked on timeout", sys_sel, 0);
      check(slips == LOCK_TMO, "R4 R10 slips until timeout", slips, LOCK_TMO);
    end
  endtask

  task automatic do_disable();
    logic [31:0] prev, expw;
    dis_req = 1'b1;
    @(negedge clk);
    dis_req = 1'b0;
    prev = ctrl_word;
    @(negedge clk);
    check(ctrl_word[23] && ctrl_word[21] == prev[21] && ctrl_word[25] == prev[25],
          "R8 bypass first", ctrl_word, prev | 32'h0080_0000);
    @(negedge clk);
    expw = (prev | 32'h0080_0000) & ~32'h0220_0000;
    check(ctrl_word == expw && done, "R8 power off second", ctrl_word, expw);
    check(out_rate == ref_rate, "R9 bypass rate", out_rate, ref_rate);
    @(negedge clk);
  endtask

  task automatic do_skip();
    logic [31:0] prev;
    prev = ctrl_word;
    en_req = 1'b1;
    @(negedge clk);
    en_req = 1'b0;
    check(done && ctrl_word == prev && sys_sel, "R6 skip when running", ctrl_word, prev);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctrl_word == 32'd0 && !sys_sel && !busy && !done && !err_timeout,
          "R1 reset state", ctrl_word, 0);
    check(out_rate == 0, "R1 R9 rate off", out_rate, 0);

    do_enable(4'd0, 6'd59, 4'd1, 6'd59, 2'd0, 0, 1'b1, 1'b0);
    do_skip();
    do_disable();
    do_enable(4'd15, 6'd63, 4'd15, 6'd63, 2'd3, 5, 1'b1, 1'b1);
    do_disable();
    do_enable(4'd2, 6'd22, 4'd1, 6'd22, 2'd1, 0, 1'b0, 1'b0);
    do_disable();
    for (int k = 0; k < 12; k++) begin
      ref_rate = 32'($urandom_range(1, 1 << 20));
      do_enable(4'($urandom), 6'($urandom), 4'($urandom), 6'($urandom), 2'($urandom),
                $urandom_range(0, 8), 1'b1, 1'($urandom));
      if (($urandom & 1) == 1) do_skip();
      do_disable();
    end
    finish_run();
  end
endmodule